// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a seven-register datapath driven entirely by a 14-bit control word presented every clock. The word picks one source for operand bus A, one for operand bus B, an arithmetic, logic or shift operation applied to the two buses, and the register that captures the result on the next rising edge. A sequencer outside the block supplies one word per cycle, so each cycle performs exactly one register-transfer microoperation.

Source code 0 on either bus selects the external data input in place of a register, so constants and incoming data can enter the register set. Destination code 0 captures nothing, which lets a word compute a value purely for the result port. The ALU result is combinational from the current word and register contents, and it is always visible on the result port.

Top module: `cw_datapath`

## Requirements
- R1: After reset, registers R1 to R7 all hold zero.
- R2: Control word bits [13:11] select bus A: code 0 is the external input, and code k (1 to 7) is register Rk.
- R3: Control word bits [10:8] select bus B with the same encoding as bus A.
- R4: Control word bits [7:5] name the destination. Code k (1 to 7) loads Rk with the ALU result at the rising edge and leaves every other register unchanged. Code 0 loads no register.
- R5: Operation codes in bits [4:0] perform arithmetic modulo 2^DATA_W: 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, 00110 gives A-1.
- R6: Logic operation codes: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, 01110 gives NOT A.
- R7: Shift operation codes act on A and fill with zero: 10000 shifts right by one bit, 11000 shifts left by one bit.
- R8: Any operation code not listed in R5 to R7 gives a result of zero.
- R9: A register may be both a source and the destination in one word. The result is computed from the value the register held before the edge.
- R10: The result port follows the control word, the external input and the register contents combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | Microoperation word: bus A select, bus B select, destination, operation |
| ext_in | input | DATA_W | External data, selectable as source code 0 |
| alu_out | output | DATA_W | ALU result for the current control word |

## Verification
On every cycle, the assertions check four things: the destination decoder raises at most one load, code 0 raises none, an unloaded register keeps its value, and a loaded register takes exactly the previous cycle's write data. They also check that passing the external input to a destination stores that input. The operation table, the bus selection codes, wraparound at the width limits, zero-fill on shifts and the zero result for unlisted codes are shown only by the bench's directed scenarios. The same holds for the same-register read-before-write case. The bench compares every result against a model of the register set that it keeps itself.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
   localparam int OP_W = 5;

   localparam logic [OP_W-1:0] OP_PASS = 5'b00000;
   localparam logic [OP_W-1:0] OP_INC  = 5'b00001;
   localparam logic [OP_W-1:0] OP_ADD  = 5'b00010;
   localparam logic [OP_W-1:0] OP_SUB  = 5'b00101;
   localparam logic [OP_W-1:0] OP_DEC  = 5'b00110;
   localparam logic [OP_W-1:0] OP_AND  = 5'b01000;
   localparam logic [OP_W-1:0] OP_OR   = 5'b01010;
   localparam logic [OP_W-1:0] OP_XOR  = 5'b01100;
   localparam logic [OP_W-1:0] OP_NOT  = 5'b01110;
   localparam logic [OP_W-1:0] OP_SHR  = 5'b10000;
   localparam logic [OP_W-1:0] OP_SHL  = 5'b11000;
endpackage

// File: rtl/cwdp_src_mux.sv
module cwdp_src_mux #(
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 3,
   parameter bit ANDOR_MUX = 1'b0
) (
   input  logic [2**SEL_W-1:0][DATA_W-1:0] bus_in,
   input  logic [SEL_W-1:0]                sel,
   output logic [DATA_W-1:0]               bus_out
);
   localparam int N_IN = 2**SEL_W;

   generate
      if (ANDOR_MUX) begin : g_andor
         logic [N_IN-1:0][DATA_W-1:0] masked;
         for (genvar i = 0; i < N_IN; i++) begin : g_term
            assign masked[i] = (sel == SEL_W'(i)) ? bus_in[i] : '0;
         end
         always_comb begin
            bus_out = '0;
            for (int j = 0; j < N_IN; j++) bus_out = bus_out | masked[j];
         end
      end else begin : g_index
         assign bus_out = bus_in[sel];
      end
   endgenerate
endmodule

// File: rtl/cwdp_alu.sv
module cwdp_alu
   import cwdp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (op)
         OP_PASS: y = a;
         OP_INC:  y = a + DATA_W'(1);
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_DEC:  y = a - DATA_W'(1);
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOT:  y = ~a;
         OP_SHR:  y = a >> 1;
         OP_SHL:  y = a << 1;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/cwdp_dest_dec.sv
module cwdp_dest_dec #(
   parameter int SEL_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SEL_W-1:0]       dst,
   output logic [2**SEL_W-1:1]    load
);
   localparam int N_REG = 2**SEL_W - 1;

   generate
      for (genvar i = 1; i <= N_REG; i++) begin : g_ld
         assign load[i] = (dst == SEL_W'(i));
      end
   endgenerate

   // R4: at most one register loads per cycle
   a_r4_onehot_load: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load));
   // R4: destination code 0 loads nothing
   a_r4_null_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (dst == '0) |-> (load == '0));
endmodule

// File: rtl/cwdp_regs.sv
module cwdp_regs #(
   parameter int DATA_W = 8,
   parameter int N_REG  = 7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_REG:1]               load,
   input  logic [DATA_W-1:0]            wdata,
   output logic [N_REG:1][DATA_W-1:0]   regs_q
);
   generate
      for (genvar i = 1; i <= N_REG; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       regs_q[i] <= '0;
            else if (load[i]) regs_q[i] <= wdata;
         end

         // R4: a register without its load keeps its value
         a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !load[i] |=> $stable(regs_q[i]));
         // R9: a loaded register takes the write data of the cycle before the edge
         a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
            load[i] |=> (regs_q[i] == $past(wdata)));
      end
   endgenerate
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
   import cwdp_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 3,
   parameter bit ANDOR_MUX = 1'b0,
   localparam int N_REG    = 2**SEL_W - 1,
   localparam int CW_W     = 3*SEL_W + OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW_W-1:0]   ctrl_word,
   input  logic [DATA_W-1:0] ext_in,
   output logic [DATA_W-1:0] alu_out
);
   generate
      if (DATA_W < 2)  begin : g_bad_w   $error("DATA_W must be at least 2"); end
      if (SEL_W != 3)  begin : g_bad_sel $error("SEL_W must be 3 for a 14-bit word"); end
   endgenerate

   logic [SEL_W-1:0] sel_a, sel_b, sel_d;
   logic [OP_W-1:0]  op;
   assign {sel_a, sel_b, sel_d, op} = ctrl_word;

   logic [N_REG:1][DATA_W-1:0]   regs_q;
   logic [N_REG:0][DATA_W-1:0]   src_bus;
   logic [DATA_W-1:0]            bus_a, bus_b;
   logic [N_REG:1]               load;

   assign src_bus = {regs_q, ext_in};

   cwdp_src_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .ANDOR_MUX(ANDOR_MUX)) u_mux_a (
      .bus_in(src_bus), .sel(sel_a), .bus_out(bus_a));
   cwdp_src_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .ANDOR_MUX(ANDOR_MUX)) u_mux_b (
      .bus_in(src_bus), .sel(sel_b), .bus_out(bus_b));

   cwdp_alu #(.DATA_W(DATA_W)) u_alu (.op(op), .a(bus_a), .b(bus_b), .y(alu_out));

   cwdp_dest_dec #(.SEL_W(SEL_W)) u_dec (.clk(clk), .rst_n(rst_n), .dst(sel_d), .load(load));

   cwdp_regs #(.DATA_W(DATA_W), .N_REG(N_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .load(load), .wdata(alu_out), .regs_q(regs_q));

   // R2: passing the external input to a destination stores that input
   a_r2_ext_store: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a == '0 && op == OP_PASS && sel_d != '0)
      |=> (src_bus[$past(sel_d)] == $past(ext_in)));
endmodule

// File: tb/cw_datapath_tb_top.sv
module cw_datapath_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [13:0]  ctrl_word = '0;
   logic [W-1:0] ext_in = '0;
   logic [W-1:0] alu_out;

   int checks = 0;
   int failures = 0;
   logic [W-1:0] model [1:7];

   always #2 clk = ~clk;

   cw_datapath #(.DATA_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_in(ext_in), .alu_out(alu_out));

   function automatic logic [13:0] mk(input int a, input int b, input int d, input logic [4:0] op);
      return {3'(a), 3'(b), 3'(d), op};
   endfunction

   function automatic logic [W-1:0] src_val(input int s, input logic [W-1:0] x);
      return (s == 0) ? x : model[s];
   endfunction

   function automatic logic [W-1:0] ref_op(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      case (op)
         5'b00000: return a;
         5'b00001: return a + 8'd1;
         5'b00010: return a + b;
         5'b00101: return a - b;
         5'b00110: return a - 8'd1;
         5'b01000: return a & b;
         5'b01010: return a | b;
         5'b01100: return a ^ b;
         5'b01110: return ~a;
         5'b10000: return {1'b0, a[W-1:1]};
         5'b11000: return {a[W-2:0], 1'b0};
         default:  return '0;
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clocked word; updates the bench's own register model
   task automatic step(input int a, input int b, input int d, input logic [4:0] op, input logic [W-1:0] x);
      logic [W-1:0] res;
      @(negedge clk);
      ctrl_word = mk(a, b, d, op);
      ext_in = x;
      res = ref_op(op, src_val(a, x), src_val(b, x));
      @(posedge clk);
      if (d != 0) model[d] = res;
   endtask

   // combinational evaluation, no write
   task automatic eval(input string req, input int a, input int b, input logic [4:0] op, input logic [W-1:0] x);
      @(negedge clk);
      ctrl_word = mk(a, b, 0, op);
      ext_in = x;
      #1;
      check(req, alu_out, ref_op(op, src_val(a, x), src_val(b, x)));
   endtask

   task automatic read_reg(input string req, input int k);
      @(negedge clk);
      ctrl_word = mk(k, 0, 0, 5'b00000);
      ext_in = 8'h5A;
      #1;
      check(req, alu_out, model[k]);
   endtask

   task automatic t_reset;
      for (int k = 1; k <= 7; k++) model[k] = '0;
      for (int k = 1; k <= 7; k++) read_reg("R1 reset zero", k);
   endtask

   task automatic t_load_all;
      for (int k = 1; k <= 7; k++) step(0, 0, k, 5'b00000, 8'(8'h13 * k + 1));
      for (int k = 1; k <= 7; k++) read_reg("R2/R4 load from ext", k);
      check("R4 R3 value", model[3], 8'h3A);
   endtask

   task automatic t_null_dest;
      step(0, 0, 0, 5'b00000, 8'hFF);
      for (int k = 1; k <= 7; k++) read_reg("R4 dest 0 writes nothing", k);
   endtask

   task automatic t_bus_b;
      eval("R3 bus B register", 1, 2, 5'b00010, 8'h00);
      eval("R3 bus B ext code 0", 1, 0, 5'b00010, 8'h05);
      eval("R3 bus B R7", 6, 7, 5'b01100, 8'h00);
   endtask

   task automatic t_arith;
      step(0, 0, 1, 5'b00000, 8'hF0);
      step(0, 0, 2, 5'b00000, 8'h20);
      eval("R5 add wraps", 1, 2, 5'b00010, 8'h00);
      check("R5 add wrap value", alu_out, 8'h10);
      eval("R5 sub", 2, 1, 5'b00101, 8'h00);
      check("R5 sub value", alu_out, 8'h30);
      eval("R5 inc wraps", 0, 0, 5'b00001, 8'hFF);
      check("R5 inc FF", alu_out, 8'h00);
      eval("R5 dec wraps", 0, 0, 5'b00110, 8'h00);
      check("R5 dec 00", alu_out, 8'hFF);
      step(1, 2, 4, 5'b00010, 8'h00);
      read_reg("R5 add stored in R4", 4);
   endtask

   task automatic t_logic;
      step(0, 0, 5, 5'b00000, 8'hC3);
      step(0, 0, 6, 5'b00000, 8'h5A);
      eval("R6 and", 5, 6, 5'b01000, 8'h00);
      eval("R6 or",  5, 6, 5'b01010, 8'h00);
      eval("R6 xor", 5, 6, 5'b01100, 8'h00);
      eval("R6 not", 5, 6, 5'b01110, 8'h00);
      check("R6 not value", alu_out, 8'h3C);
   endtask

   task automatic t_shift;
      eval("R7 shr", 0, 0, 5'b10000, 8'h81);
      check("R7 shr zero fill", alu_out, 8'h40);
      eval("R7 shl", 0, 0, 5'b11000, 8'h81);
      check("R7 shl zero fill", alu_out, 8'h02);
   endtask

   task automatic t_undef;
      eval("R8 op 00011", 0, 0, 5'b00011, 8'h77);
      check("R8 zero", alu_out, 8'h00);
      eval("R8 op 11111", 5, 6, 5'b11111, 8'h00);
      check("R8 zero b", alu_out, 8'h00);
   endtask

   task automatic t_self_update;
      step(0, 0, 3, 5'b00000, 8'h21);
      step(3, 3, 3, 5'b00010, 8'h00);
      read_reg("R9 R3<=R3+R3", 3);
      check("R9 value", model[3], 8'h42);
      step(3, 0, 3, 5'b00001, 8'h00);
      read_reg("R9 R3<=R3+1", 3);
   endtask

   task automatic t_comb;
      @(negedge clk);
      ctrl_word = mk(0, 0, 0, 5'b00000);
      ext_in = 8'h9E;
      #1;
      check("R10 same-cycle pass", alu_out, 8'h9E);
      ext_in = 8'h61;
      #1;
      check("R10 follows ext", alu_out, 8'h61);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_all();
      t_null_dest();
      t_bus_b();
      t_arith();
      t_logic();
      t_shift();
      t_undef();
      t_self_update();
      t_comb();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule